// File: doc/BRIEF.md
# Chip-Select-Gated Dual-Copy Command Register

This block sits between a memory controller and a pair of memory loads. On every rising clock edge it registers a command word and drives two identical copies of each registered bit, copy A and copy B, so that each copy can feed its own set of loads. The command word has two parts. The first is a 22-bit address/command field: sixteen address bits, three bank-select bits and the row-strobe, column-strobe and write-enable bits. The second is a set of per-rank control bits: two active-low chip selects, two clock enables and two termination enables.

The address/command field can be gated to save switching power. When the static gating input is high, the field updates only on an edge where at least one chip select is low. When both chip selects are high, the field holds its old value. When the gating input is low, the field updates on every edge. The control bits are never gated. An asynchronous active-low reset clears every flop and drives every output low at once, and it overrides the gating logic.

Top module: `cmd_fanout_reg`

## Requirements
- R1: With `gate_en` high, a rising edge on which at least one bit of `cs_n_in` is 0 loads `cmd_in` into `cmd_a` and `cmd_b`. The new value is visible right after that edge.
- R2: With `gate_en` high, a rising edge on which both bits of `cs_n_in` are 1 leaves `cmd_a` and `cmd_b` unchanged, whatever `cmd_in` carries.
- R3: With `gate_en` low, every rising edge loads `cmd_in` into both command copies, for every value of `cs_n_in`.
- R4: `cs_n_in`, `cke_in` and `odt_in` are loaded into their A and B outputs on every rising edge, whatever `gate_en` and `cs_n_in` are.
- R5: Outside reset, each A output equals its B output on every cycle. The two copies come from separate flops.
- R6: Driving `rst_n` low between clock edges forces every output to 0 at once, without waiting for a clock edge. The outputs stay 0 for as long as `rst_n` is low, even when `cs_n_in` is active.
- R7: After `rst_n` is released, the outputs stay 0 until the next rising edge. That edge follows R1 to R4. With gating on and both selects high, the command copies stay 0 while the control copies load.
- R8: `gate_en` is sampled on the same edge as the data. Dropping it while both selects are high makes that very edge load `cmd_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1 = command field updates only when a chip select is low |
| cs_n_in | input | 2 | Chip selects, active low |
| cke_in | input | 2 | Clock enables |
| odt_in | input | 2 | Termination enables |
| cmd_in | input | 22 | Address/command field: [15:0] address, [18:16] bank, [19] row strobe, [20] column strobe, [21] write enable |
| cmd_a | output | 22 | Registered command field, copy A |
| cmd_b | output | 22 | Registered command field, copy B |
| cs_n_a | output | 2 | Registered chip selects, copy A |
| cs_n_b | output | 2 | Registered chip selects, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination enables, copy A |
| odt_b | output | 2 | Registered termination enables, copy B |

## Verification
The bench sweeps both gating modes against all four chip-select combinations. It uses a fresh arithmetic command pattern on each edge, so a held value can never be mistaken for a newly loaded one. This separates gating that ignores the mode input, gating that looks at only one select, and the wrong choice between AND and OR of the selects. The control bits get their own pattern, which changes every cycle, so any gating applied to them by mistake shows up. A reset is applied between two edges and held through an edge with a select active. It is then released into a gated, deselected edge. This checks that the clear takes effect at once and that the first edge after reset follows the normal rules.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int ADDR_BITS   = 16;
  localparam int BANK_BITS   = 3;
  localparam int STROBE_BITS = 3;
  localparam int RANKS       = 2;
  localparam int COPIES      = 2;
endpackage

// File: rtl/capture_gate.sv
module capture_gate #(
  parameter int NSEL = 2
) (
  input  logic            gate_en,
  input  logic [NSEL-1:0] cs_n,
  output logic            load_en
);
  logic any_sel;
  assign any_sel = ~(&cs_n);
  assign load_en = ~gate_en | any_sel;
endmodule

// File: rtl/lane_reg.sv
module lane_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q == $past(d));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
  always_ff @(negedge clk) begin
    if (!rst_n) assert_reset_clear_R6: assert (q == '0);
  end
endmodule

// File: rtl/cmd_fanout_reg.sv
module cmd_fanout_reg
  import cmdreg_pkg::*;
#(
  parameter int AW   = ADDR_BITS,
  parameter int BW   = BANK_BITS,
  parameter int NSEL = RANKS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          gate_en,
  input  logic [NSEL-1:0]               cs_n_in,
  input  logic [NSEL-1:0]               cke_in,
  input  logic [NSEL-1:0]               odt_in,
  input  logic [AW+BW+STROBE_BITS-1:0]  cmd_in,
  output logic [AW+BW+STROBE_BITS-1:0]  cmd_a,
  output logic [AW+BW+STROBE_BITS-1:0]  cmd_b,
  output logic [NSEL-1:0]               cs_n_a,
  output logic [NSEL-1:0]               cs_n_b,
  output logic [NSEL-1:0]               cke_a,
  output logic [NSEL-1:0]               cke_b,
  output logic [NSEL-1:0]               odt_a,
  output logic [NSEL-1:0]               odt_b
);
  localparam int GW = AW + BW + STROBE_BITS;
  localparam int FW = 3 * NSEL;

  logic          load_en;
  logic [FW-1:0] ctl_d;
  logic [GW-1:0] cmd_q [COPIES];
  logic [FW-1:0] ctl_q [COPIES];

  capture_gate #(.NSEL(NSEL)) u_gate (
    .gate_en (gate_en),
    .cs_n    (cs_n_in),
    .load_en (load_en)
  );

  assign ctl_d = {cs_n_in, cke_in, odt_in};

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    lane_reg #(.W(GW)) u_cmd (
      .clk (clk), .rst_n (rst_n), .en (load_en),
      .d   (cmd_in), .q (cmd_q[c])
    );
    lane_reg #(.W(FW)) u_ctl (
      .clk (clk), .rst_n (rst_n), .en (1'b1),
      .d   (ctl_d), .q (ctl_q[c])
    );
  end

  assign cmd_a  = cmd_q[0];
  assign cmd_b  = cmd_q[1];
  assign cs_n_a = ctl_q[0][FW-1 -: NSEL];
  assign cs_n_b = ctl_q[1][FW-1 -: NSEL];
  assign cke_a  = ctl_q[0][2*NSEL-1 -: NSEL];
  assign cke_b  = ctl_q[1][2*NSEL-1 -: NSEL];
  assign odt_a  = ctl_q[0][NSEL-1:0];
  assign odt_b  = ctl_q[1][NSEL-1:0];

  assert_gated_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !(&cs_n_in)) |=> cmd_a == $past(cmd_in));
  assert_gated_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n_in)) |=> $stable(cmd_b));
  assert_open_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> cmd_b == $past(cmd_in));
  assert_ctl_every_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cke_a == $past(cke_in)) && (odt_b == $past(odt_in))
              && (cs_n_a == $past(cs_n_in)));
  always_ff @(negedge clk) begin
    if (rst_n) assert_copies_match_R5: assert (cmd_a == cmd_b && cs_n_a == cs_n_b
                                               && cke_a == cke_b && odt_a == odt_b);
  end
endmodule

// File: tb/test_cmd_fanout_reg.sv
module test_cmd_fanout_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        gate_en = 1'b0;
  logic [1:0]  cs_n_in = 2'b11, cke_in = '0, odt_in = '0;
  logic [21:0] cmd_in = '0;
  logic [21:0] cmd_a, cmd_b;
  logic [1:0]  cs_n_a, cs_n_b, cke_a, cke_b, odt_a, odt_b;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [21:0] e_cmd = '0;
  logic [1:0]  e_cs = '0, e_cke = '0, e_odt = '0;

  always #10 clk = ~clk;

  cmd_fanout_reg i_cmd_fanout_reg (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n_in(cs_n_in),
    .cke_in(cke_in), .odt_in(odt_in), .cmd_in(cmd_in),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cs_n_a(cs_n_a), .cs_n_b(cs_n_b),
    .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " cmd_a"}, 32'(cmd_a), 32'(e_cmd));
    check({tag, " cmd_b R5"}, 32'(cmd_b), 32'(e_cmd));
    check({tag, " ctl_a R4"}, 32'({cs_n_a, cke_a, odt_a}), 32'({e_cs, e_cke, e_odt}));
    check({tag, " ctl_b R5"}, 32'({cs_n_b, cke_b, odt_b}), 32'({e_cs, e_cke, e_odt}));
  endtask

  task automatic step(string tag, logic ge, logic [1:0] cs, logic [1:0] ck,
                      logic [1:0] od, logic [21:0] cmd);
    @(negedge clk);
    gate_en = ge; cs_n_in = cs; cke_in = ck; odt_in = od; cmd_in = cmd;
    @(posedge clk);
    #5;
    if (!ge || cs != 2'b11) e_cmd = cmd;
    e_cs = cs; e_cke = ck; e_odt = od;
    check_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk); #2;
    check_all("R6 reset state");
    @(negedge clk); rst_n = 1'b1;

    // sweep: both modes, every select combination, changing patterns
    for (int ge = 0; ge < 2; ge++)
      for (int cs = 0; cs < 4; cs++)
        for (int k = 0; k < 4; k++) begin
          int n = ge * 16 + cs * 4 + k;
          string t;
          t = (ge == 0) ? "R3" : ((cs == 3) ? "R2" : "R1");
          step(t, ge[0], cs[1:0], n[1:0], n[2:1] ^ 2'b01,
               22'((n + 1) * 32'h2F1B3 ^ 32'h15A5A5));
        end

    // gating mode picked up on the same edge
    step("R2 pre", 1'b1, 2'b11, 2'b10, 2'b01, 22'h3ABCDE);
    step("R8 drop gate", 1'b0, 2'b11, 2'b01, 2'b10, 22'h012345);
    step("R8 raise gate", 1'b1, 2'b11, 2'b11, 2'b11, 22'h2AAAAA);

    // reset between edges
    @(posedge clk); #3;
    rst_n = 1'b0; #1;
    e_cmd = '0; e_cs = '0; e_cke = '0; e_odt = '0;
    check_all("R6 mid-cycle clear");
    @(negedge clk);
    gate_en = 1'b1; cs_n_in = 2'b00; cke_in = 2'b11; odt_in = 2'b11; cmd_in = 22'h1FFFFF;
    @(posedge clk); #5;
    check_all("R6 held through edge");
    @(negedge clk);
    rst_n = 1'b1; cs_n_in = 2'b11; cke_in = 2'b10; odt_in = 2'b01; cmd_in = 22'h155555;
    #2;
    check_all("R7 before first edge");
    @(posedge clk); #5;
    e_cs = 2'b11; e_cke = 2'b10; e_odt = 2'b01;
    check_all("R7 first edge");
    step("R1 after reset", 1'b1, 2'b10, 2'b00, 2'b00, 22'h0F0F0F);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule